// File: doc/BRIEF.md
# Vector Slide-Down Permutation Unit

This unit computes the result of a slide-down permutation on one vector register image. Each active destination element `i` takes the source element at position `i + shift`, where `shift` is a zero-extended 5-bit immediate. A source position at or beyond the maximum element count (`vlmax`) gives zero, so data drains out of the top of the vector and zeros fill in behind it.

Each destination element falls into one of three classes, and all three are resolved in one result. Body elements with a set mask bit, or any body element while masking is off, receive slid data. Body elements with a clear mask bit follow the mask policy. Elements at or above the active length `vl` follow the tail policy. Under either policy, "keep" retains the old destination element and "fill" writes all ones. The whole result comes from the source image as presented with the request, so the source and destination may be the same register. The result is registered and appears one cycle after the request.

Top module: `vslide_down_unit`

## Requirements
- R1: While reset is held and after reset is released with no request, `out_valid` is 0 and `dst_vec` is all zeros.
- R2: `out_valid` is 1 in exactly the cycle after each cycle with `in_valid` high and is 0 otherwise. Requests on consecutive cycles produce results on consecutive cycles.
- R3: Element `i` occupies bits `[i*EW +: EW]` of each vector. An active body element `i` receives source element `i + shift`, where `shift` is read as an unsigned value from 0 to 31.
- R4: When `i + shift >= vlmax`, or `i + shift >= NE`, an active body element is written with zero. The sum is formed wide enough that it never wraps.
- R5: When `mask_en` is 1, a body element whose mask bit `mask_vec[i]` is 0 is inactive. With `mask_pol` = 0 (keep) it takes the old destination element, and with `mask_pol` = 1 (fill) it is written with all ones.
- R6: When `mask_en` is 0, every body element is active whatever `mask_vec` holds.
- R7: An element with `i >= vl` is a tail element, whatever its mask bit. With `tail_pol` = 0 (keep) it takes the old destination element, and with `tail_pol` = 1 (fill) it is written with all ones.
- R8: With `shift` = 0, active body elements are copied unchanged from the source to the destination.
- R9: The result depends only on the vectors presented with the request, so a request whose source and old destination images are identical (the same register) slides correctly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe; inputs are captured in this cycle |
| src_vec | input | NE*EW | Source vector image |
| old_vec | input | NE*EW | Previous destination vector image |
| mask_vec | input | NE | One mask bit per element |
| mask_en | input | 1 | 1: masking applies; 0: all body elements are active |
| vl | input | IW | Active vector length |
| vlmax | input | IW | Maximum element count for the bound check |
| shift | input | 5 | Unsigned slide distance |
| tail_pol | input | 1 | Tail policy: 0 keep, 1 fill with ones |
| mask_pol | input | 1 | Inactive policy: 0 keep, 1 fill with ones |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| dst_vec | output | NE*EW | New destination vector image |

## Verification
Every result is due exactly one rising edge after its request is captured. The driver applies each request at a falling edge and queues the expected image at the same moment. The monitor samples 2 ns after each rising edge. At that point the queue holds an item exactly when `out_valid` must be high. Each sampled `out_valid` is compared with the queue state, and each result is compared with the popped item. Back-to-back requests therefore test the one-cycle spacing directly, and idle gaps test that no extra strobe appears.

// File: rtl/vsd_pkg.sv
package vsd_pkg;

    // Policy applied to an element that does not receive slid data
    typedef enum logic {
        POL_KEEP = 1'b0,
        POL_FILL = 1'b1
    } pol_e;

    // Classification of one destination element
    typedef enum logic [1:0] {
        EL_ACTIVE   = 2'd0,
        EL_INACTIVE = 2'd1,
        EL_TAIL     = 2'd2
    } elem_cls_e;

    localparam int SHIFT_W = 5;

endpackage

// File: rtl/vsd_gather.sv
module vsd_gather #(
    parameter int NE = 8,
    parameter int EW = 8,
    parameter int IW = 4,
    parameter int SW = 6
) (
    input  logic [NE*EW-1:0]           src_vec,
    input  logic [IW-1:0]              vlmax,
    input  logic [vsd_pkg::SHIFT_W-1:0] shift,
    output logic [NE*EW-1:0]           slid_vec
);

    localparam logic [SW-1:0] NE_S = SW'(NE);

    for (genvar gi = 0; gi < NE; gi++) begin : g_el
        logic [SW-1:0] pos_s;
        logic          in_rng;
        logic [EW-1:0] pick;

        // Widened sum: cannot wrap for any index or shift
        assign pos_s  = SW'(gi) + SW'(shift);
        assign in_rng = (pos_s < SW'(vlmax)) && (pos_s < NE_S);

        always_comb begin
            pick = '0;
            for (int j = gi; j < NE; j++) begin
                if (pos_s == SW'(j)) pick = src_vec[j*EW +: EW];
            end
        end

        assign slid_vec[gi*EW +: EW] = in_rng ? pick : '0;
    end

endmodule

// File: rtl/vsd_classify.sv
module vsd_classify #(
    parameter int NE = 8,
    parameter int IW = 4
) (
    input  logic [NE-1:0]        mask_vec,
    input  logic                 mask_en,
    input  logic [IW-1:0]        vl,
    output vsd_pkg::elem_cls_e   cls [NE]
);

    localparam int CW = (IW > $clog2(NE) + 1) ? IW : $clog2(NE) + 1;

    for (genvar gi = 0; gi < NE; gi++) begin : g_cls
        always_comb begin
            if (CW'(gi) >= CW'(vl))
                cls[gi] = vsd_pkg::EL_TAIL;
            else if (mask_en && !mask_vec[gi])
                cls[gi] = vsd_pkg::EL_INACTIVE;
            else
                cls[gi] = vsd_pkg::EL_ACTIVE;
        end
    end

endmodule

// File: rtl/vsd_merge.sv
module vsd_merge #(
    parameter int NE = 8,
    parameter int EW = 8
) (
    input  logic [NE*EW-1:0]         slid_vec,
    input  logic [NE*EW-1:0]         old_vec,
    input  vsd_pkg::elem_cls_e       cls [NE],
    input  vsd_pkg::pol_e            tail_pol,
    input  vsd_pkg::pol_e            mask_pol,
    output logic [NE*EW-1:0]         res_vec
);

    for (genvar gi = 0; gi < NE; gi++) begin : g_mrg
        logic [EW-1:0] old_e;
        assign old_e = old_vec[gi*EW +: EW];

        always_comb begin
            unique case (cls[gi])
                vsd_pkg::EL_ACTIVE:
                    res_vec[gi*EW +: EW] = slid_vec[gi*EW +: EW];
                vsd_pkg::EL_INACTIVE:
                    res_vec[gi*EW +: EW] = (mask_pol == vsd_pkg::POL_FILL) ? '1 : old_e;
                default:
                    res_vec[gi*EW +: EW] = (tail_pol == vsd_pkg::POL_FILL) ? '1 : old_e;
            endcase
        end
    end

endmodule

// File: rtl/vslide_down_unit.sv
module vslide_down_unit #(
    parameter int NE = 8,
    parameter int EW = 8,
    parameter int IW = $clog2(NE + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic [NE*EW-1:0]      src_vec,
    input  logic [NE*EW-1:0]      old_vec,
    input  logic [NE-1:0]         mask_vec,
    input  logic                  mask_en,
    input  logic [IW-1:0]         vl,
    input  logic [IW-1:0]         vlmax,
    input  logic [4:0]            shift,
    input  logic                  tail_pol,
    input  logic                  mask_pol,
    output logic                  out_valid,
    output logic [NE*EW-1:0]      dst_vec
);

    localparam int SW = ((IW > vsd_pkg::SHIFT_W) ? IW : vsd_pkg::SHIFT_W) + 1;

    typedef struct packed {
        logic             vld;
        logic [NE*EW-1:0] data;
    } out_st_t;

    out_st_t             st_d, st_q;
    logic [NE*EW-1:0]    slid_w;
    logic [NE*EW-1:0]    res_w;
    vsd_pkg::elem_cls_e  cls_w [NE];

    vsd_gather #(.NE(NE), .EW(EW), .IW(IW), .SW(SW)) u_gather (
        .src_vec  (src_vec),
        .vlmax    (vlmax),
        .shift    (shift),
        .slid_vec (slid_w)
    );

    vsd_classify #(.NE(NE), .IW(IW)) u_classify (
        .mask_vec (mask_vec),
        .mask_en  (mask_en),
        .vl       (vl),
        .cls      (cls_w)
    );

    vsd_merge #(.NE(NE), .EW(EW)) u_merge (
        .slid_vec (slid_w),
        .old_vec  (old_vec),
        .cls      (cls_w),
        .tail_pol (vsd_pkg::pol_e'(tail_pol)),
        .mask_pol (vsd_pkg::pol_e'(mask_pol)),
        .res_vec  (res_w)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) st_d.data = res_w;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.vld;
    assign dst_vec   = st_q.data;

endmodule

// File: rtl/vsd_chk.sv
module vsd_chk #(
    parameter int NE = 8,
    parameter int EW = 8,
    parameter int IW = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [NE*EW-1:0]  src_vec,
    input logic [NE*EW-1:0]  old_vec,
    input logic [NE-1:0]     mask_vec,
    input logic              mask_en,
    input logic [IW-1:0]     vl,
    input logic [IW-1:0]     vlmax,
    input logic [4:0]        shift,
    input logic              tail_pol,
    input logic              mask_pol,
    input logic              out_valid,
    input logic [NE*EW-1:0]  dst_vec
);

    // R2
    valid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R2
    no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R8
    zero_shift_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && shift == 5'd0 && !mask_en && vl == IW'(NE) && vlmax == IW'(NE))
        |=> dst_vec == $past(src_vec));

    // R7
    tail_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && vl == '0 && tail_pol) |=> dst_vec == '1);

    // R7
    tail_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && vl == '0 && !tail_pol) |=> dst_vec == $past(old_vec));

    // R4
    bound_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && vl != '0 && !mask_en && {1'b0, shift} >= 6'(vlmax))
        |=> dst_vec[EW-1:0] == '0);

    // R5
    mask_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mask_en && vl != '0 && !mask_vec[0] && !mask_pol)
        |=> dst_vec[EW-1:0] == $past(old_vec[EW-1:0]));

endmodule

bind vslide_down_unit vsd_chk #(.NE(NE), .EW(EW), .IW(IW)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src_vec(src_vec),
    .old_vec(old_vec), .mask_vec(mask_vec), .mask_en(mask_en), .vl(vl),
    .vlmax(vlmax), .shift(shift), .tail_pol(tail_pol), .mask_pol(mask_pol),
    .out_valid(out_valid), .dst_vec(dst_vec)
);

// File: tb/sim_vslide_down_unit.sv
`timescale 1ns/1ps
module sim_vslide_down_unit;

    localparam int NE = 8;
    localparam int EW = 8;
    localparam int IW = $clog2(NE + 1);
    localparam int VW = NE * EW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [VW-1:0] src_vec = '0;
    logic [VW-1:0] old_vec = '0;
    logic [NE-1:0] mask_vec = '0;
    logic          mask_en = 1'b0;
    logic [IW-1:0] vl = '0;
    logic [IW-1:0] vlmax = '0;
    logic [4:0]    shift = '0;
    logic          tail_pol = 1'b0;
    logic          mask_pol = 1'b0;
    logic          out_valid;
    logic [VW-1:0] dst_vec;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    logic [VW-1:0] exp_q [$];
    string         tag_q [$];

    always #4 clk = ~clk;

    vslide_down_unit #(.NE(NE), .EW(EW)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src_vec(src_vec),
        .old_vec(old_vec), .mask_vec(mask_vec), .mask_en(mask_en), .vl(vl),
        .vlmax(vlmax), .shift(shift), .tail_pol(tail_pol), .mask_pol(mask_pol),
        .out_valid(out_valid), .dst_vec(dst_vec)
    );

    function automatic logic [VW-1:0] model(
        input logic [VW-1:0] s, input logic [VW-1:0] o, input logic [NE-1:0] m,
        input logic me, input int l, input int lmax, input int off,
        input logic tp, input logic mp);
        logic [VW-1:0] r;
        for (int i = 0; i < NE; i++) begin
            if (i >= l)               r[i*EW +: EW] = tp ? '1 : o[i*EW +: EW];
            else if (me && !m[i])     r[i*EW +: EW] = mp ? '1 : o[i*EW +: EW];
            else if (i + off >= lmax || i + off >= NE) r[i*EW +: EW] = '0;
            else                      r[i*EW +: EW] = s[(i + off)*EW +: EW];
        end
        return r;
    endfunction

    task automatic check(input string req, input logic [VW-1:0] act, input logic [VW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive(input string tag, input logic [VW-1:0] s, input logic [VW-1:0] o,
                         input logic [NE-1:0] m, input logic me, input int l, input int lmax,
                         input int off, input logic tp, input logic mp);
        @(negedge clk);
        in_valid = 1'b1; src_vec = s; old_vec = o; mask_vec = m; mask_en = me;
        vl = IW'(l); vlmax = IW'(lmax); shift = 5'(off); tail_pol = tp; mask_pol = mp;
        exp_q.push_back(model(s, o, m, me, l, lmax, off, tp, mp));
        tag_q.push_back(tag);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    // Monitor: samples 2 ns after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (rst_n && (out_valid || exp_q.size() != 0)) begin
                check("R2 valid", {{(VW-1){1'b0}}, out_valid},
                      {{(VW-1){1'b0}}, exp_q.size() != 0});
                if (exp_q.size() != 0) begin
                    string t;
                    logic [VW-1:0] e;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(t, dst_vec, e);
                end
            end
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    localparam logic [VW-1:0] SEQ = 64'h8877665544332211;
    localparam logic [VW-1:0] OLD = 64'hA0A1A2A3A4A5A6A7;

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset valid", {{(VW-1){1'b0}}, out_valid}, '0);
        check("R1 reset data", dst_vec, '0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R1 idle valid", {{(VW-1){1'b0}}, out_valid}, '0);
        check("R1 idle data", dst_vec, '0);

        drive("R8 zero shift copy",    SEQ, OLD, 8'h00, 1'b0, 8, 8, 0, 1'b0, 1'b0);
        drive("R3 shift 3",            SEQ, OLD, 8'hFF, 1'b0, 8, 8, 3, 1'b0, 1'b0);
        drive("R4 shift 31 all zero",  SEQ, OLD, 8'hFF, 1'b0, 8, 8, 31, 1'b1, 1'b1);
        idle(2);
        drive("R4 vlmax 4 bound",      SEQ, OLD, 8'hFF, 1'b0, 4, 4, 1, 1'b0, 1'b0);
        drive("R4 vlmax 6 shift 7",    SEQ, OLD, 8'hFF, 1'b0, 6, 6, 7, 1'b0, 1'b0);
        drive("R5 mask keep",          SEQ, OLD, 8'hA5, 1'b1, 8, 8, 2, 1'b0, 1'b0);
        drive("R5 mask fill",          SEQ, OLD, 8'hA5, 1'b1, 8, 8, 2, 1'b0, 1'b1);
        drive("R6 mask disabled",      SEQ, OLD, 8'h00, 1'b0, 8, 8, 1, 1'b0, 1'b1);
        idle(1);
        drive("R7 tail keep",          SEQ, OLD, 8'hFF, 1'b0, 5, 8, 1, 1'b0, 1'b0);
        drive("R7 tail fill",          SEQ, OLD, 8'hFF, 1'b0, 5, 8, 1, 1'b1, 1'b0);
        drive("R7 tail over mask",     SEQ, OLD, 8'h0F, 1'b1, 3, 8, 0, 1'b1, 1'b0);
        drive("R7 vl zero",            SEQ, OLD, 8'hFF, 1'b1, 0, 8, 2, 1'b0, 1'b1);
        drive("R9 same register",      SEQ, SEQ, 8'h6F, 1'b1, 7, 8, 2, 1'b1, 1'b0);
        drive("R8 zero shift masked",  SEQ, OLD, 8'h3C, 1'b1, 6, 8, 0, 1'b0, 1'b1);
        idle(3);

        for (int n = 0; n < 40; n++) begin
            drive("R3 mixed", {$urandom, $urandom}, {$urandom, $urandom},
                  8'($urandom), 1'($urandom), int'($urandom % 9), 8 - int'($urandom % 3),
                  int'($urandom % 32), 1'($urandom), 1'($urandom));
            if (n % 5 == 4) idle(1);
        end
        idle(4);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule